// File: doc/BRIEF.md
# Quadrature x4 Position Counter

This block turns a pair of already-filtered incremental encoder phases into a signed-free position count of `CNT_W` bits. It advances or retreats by one on every edge of either phase, so a full electrical cycle of the encoder yields four counts. The phase and index inputs can each be inverted, and the two phases can be exchanged, so that a wiring or mounting difference can be corrected without touching the board.

Two reset schemes are selectable. In ceiling mode the count runs between 0 and a programmable limit and wraps at either end. In index mode the count runs freely modulo 2^CNT_W and is returned to zero by an index pulse, but only when the phase levels sampled with that pulse match one of four programmable A/B combinations. Single-cycle event pulses report a direction change, a reset while moving up, a reset while moving down, and an illegal double transition of the phases. A sticky flag remembers the last illegal transition.

All outputs are registered: an input change presented before a clock edge is reflected on the outputs just after that edge.

Top module: `quad_pos_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0, `dir_up` is 1, all event outputs are 0 and `phase_err_sticky` is 0.
- R2: With the conditioned phases written as {A,B}, each single-bit step along 00, 10, 11, 01, 00 is a forward step and raises `count` by one on the edge that samples it.
- R3: Each single-bit step along the reverse order 00, 01, 11, 10, 00 lowers `count` by one.
- R4: `inv_a` and `inv_b` invert the respective phase and `inv_idx` inverts the index before any decoding, so an inversion alone can create a counted step or an index edge.
- R5: With `swap_ab` set, the phase A pin is used as B and the B pin as A (after inversion), which reverses the counting direction for the same pin waveform.
- R6: In ceiling mode (`ceil_mode` = 1), a forward step while `count` equals `ceiling` loads 0 and pulses `evt_wrap_up` for one cycle.
- R7: In ceiling mode, a backward step while `count` is 0 loads `ceiling` and pulses `evt_wrap_dn` for one cycle.
- R8: In index mode (`ceil_mode` = 0), a rising edge of the conditioned index while the conditioned {A,B} equals `idx_gate` (bit 1 = A level, bit 0 = B level: 0 both low, 1 A low B high, 2 A high B low, 3 both high) loads 0, wins over a step in the same cycle, and pulses `evt_wrap_up` if the resulting direction is up, else `evt_wrap_dn`; a non-matching index edge, or any index edge in ceiling mode, is ignored.
- R9: In index mode, steps wrap modulo 2^CNT_W with no event pulse.
- R10: A step opposite to `dir_up` flips `dir_up` and pulses `evt_dir_chg` in the same output cycle.
- R11: A change of both conditioned phases between two samples leaves `count` and `dir_up` unchanged, pulses `evt_phase_err` and sets `phase_err_sticky`, which stays set until the next rise of `enable`.
- R12: While `enable` is low, `count` holds and no event pulses; on the cycle `enable` rises, `count` and `phase_err_sticky` clear and that cycle's step is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Counting enable |
| inv_a | input | 1 | Invert phase A pin |
| inv_b | input | 1 | Invert phase B pin |
| inv_idx | input | 1 | Invert index pin |
| swap_ab | input | 1 | Exchange phase A and phase B |
| idx_gate | input | 2 | A/B levels that qualify an index edge |
| ceil_mode | input | 1 | 1: wrap at ceiling, 0: reset on qualified index |
| ceiling | input | CNT_W | Upper count limit in ceiling mode |
| phase_a | input | 1 | Filtered phase A pin |
| phase_b | input | 1 | Filtered phase B pin |
| index_in | input | 1 | Filtered index pin |
| count | output | CNT_W | Position count |
| dir_up | output | 1 | Direction of the last counted step, 1 = up |
| evt_dir_chg | output | 1 | One-cycle pulse on a direction change |
| evt_wrap_up | output | 1 | One-cycle pulse on a reset while moving up |
| evt_wrap_dn | output | 1 | One-cycle pulse on a reset while moving down |
| evt_phase_err | output | 1 | One-cycle pulse on an illegal double transition |
| phase_err_sticky | output | 1 | Set by a phase error, cleared when enable rises |

## Verification
The qualified index preset and a phase step can land on the same clock edge, and so can a direction reversal and a wrap. The bench moves the phases from 11 to 10 in the very cycle the index rises with `idx_gate` set to A high, B low, so the step alone would have decremented. The expected result is a count of 0 with `evt_wrap_dn` and `evt_dir_chg` both pulsing, and a backward step from 0 in ceiling mode is likewise expected to load the ceiling while reporting the reversal.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    // Encoded so that the value equals the modulo-4 position difference
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_ERR  = 2'd2,
        STEP_DN   = 2'd3
    } step_e;

    // One conditioned sample: ab = {A, B}
    typedef struct packed {
        logic [1:0] ab;
        logic       idx;
    } smp_t;

endpackage

// File: rtl/qpc_input_cond.sv
module qpc_input_cond
    import qpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_a,
    input  logic raw_b,
    input  logic raw_idx,
    input  logic inv_a,
    input  logic inv_b,
    input  logic inv_idx,
    input  logic swap_ab,
    output smp_t cur,
    output smp_t prev
);

    logic cond_a;
    logic cond_b;
    smp_t prev_d;
    smp_t prev_q;

    always_comb begin
        cond_a  = raw_a ^ inv_a;
        cond_b  = raw_b ^ inv_b;
        cur.ab  = swap_ab ? {cond_b, cond_a} : {cond_a, cond_b};
        cur.idx = raw_idx ^ inv_idx;
        prev_d  = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign prev = prev_q;

endmodule

// File: rtl/qpc_step_decode.sv
module qpc_step_decode
    import qpc_pkg::*;
(
    input  logic [1:0] old_ab,
    input  logic [1:0] new_ab,
    output step_e      step
);

    // Position along the forward cycle 00,10,11,01 -> 0,1,2,3
    function automatic logic [1:0] ab_to_pos(input logic [1:0] ab);
        return {ab[0], ab[1] ^ ab[0]};
    endfunction

    logic [1:0] delta;

    always_comb begin
        delta = ab_to_pos(new_ab) - ab_to_pos(old_ab);
        step  = step_e'(delta);
    end

endmodule

// File: rtl/qpc_index_qual.sv
module qpc_index_qual
    import qpc_pkg::*;
(
    input  smp_t       cur,
    input  smp_t       prev,
    input  logic [1:0] gate,
    output logic       hit
);

    logic idx_rise;
    logic lvl_match;

    always_comb begin
        idx_rise  = cur.idx & ~prev.idx;
        lvl_match = (cur.ab == gate);
        hit       = idx_rise & lvl_match;
    end

endmodule

// File: rtl/qpc_count_core.sv
module qpc_count_core
    import qpc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             ceil_mode,
    input  logic [CNT_W-1:0] ceiling,
    input  step_e            step,
    input  logic             idx_hit,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             evt_dir_chg,
    output logic             evt_wrap_up,
    output logic             evt_wrap_dn,
    output logic             evt_phase_err,
    output logic             phase_err_sticky
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
        logic             en;
        logic             sticky;
        logic             dir_chg;
        logic             wrap_up;
        logic             wrap_dn;
        logic             perr;
    } core_t;

    core_t st_d;
    core_t st_q;
    logic  dir_nxt;
    logic  at_top;
    logic  at_bottom;

    always_comb begin
        st_d         = st_q;
        st_d.dir_chg = 1'b0;
        st_d.wrap_up = 1'b0;
        st_d.wrap_dn = 1'b0;
        st_d.perr    = 1'b0;
        st_d.en      = enable;
        at_top       = (st_q.cnt == ceiling);
        at_bottom    = (st_q.cnt == CNT_ZERO);
        dir_nxt      = st_q.dir;
        if (step == STEP_UP) begin
            dir_nxt = 1'b1;
        end else if (step == STEP_DN) begin
            dir_nxt = 1'b0;
        end

        if (enable && !st_q.en) begin
            st_d.cnt    = CNT_ZERO;
            st_d.sticky = 1'b0;
        end else if (enable) begin
            if (step == STEP_ERR) begin
                st_d.perr   = 1'b1;
                st_d.sticky = 1'b1;
            end else begin
                st_d.dir     = dir_nxt;
                st_d.dir_chg = (dir_nxt != st_q.dir);
                if (!ceil_mode && idx_hit) begin
                    st_d.cnt     = CNT_ZERO;
                    st_d.wrap_up = dir_nxt;
                    st_d.wrap_dn = ~dir_nxt;
                end else if (step == STEP_UP) begin
                    if (ceil_mode && at_top) begin
                        st_d.cnt     = CNT_ZERO;
                        st_d.wrap_up = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_ONE;
                    end
                end else if (step == STEP_DN) begin
                    if (ceil_mode && at_bottom) begin
                        st_d.cnt     = ceiling;
                        st_d.wrap_dn = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - CNT_ONE;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.dir <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count            = st_q.cnt;
    assign dir_up           = st_q.dir;
    assign evt_dir_chg      = st_q.dir_chg;
    assign evt_wrap_up      = st_q.wrap_up;
    assign evt_wrap_dn      = st_q.wrap_dn;
    assign evt_phase_err    = st_q.perr;
    assign phase_err_sticky = st_q.sticky;

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import qpc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             inv_a,
    input  logic             inv_b,
    input  logic             inv_idx,
    input  logic             swap_ab,
    input  logic [1:0]       idx_gate,
    input  logic             ceil_mode,
    input  logic [CNT_W-1:0] ceiling,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic             index_in,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             evt_dir_chg,
    output logic             evt_wrap_up,
    output logic             evt_wrap_dn,
    output logic             evt_phase_err,
    output logic             phase_err_sticky
);

    smp_t  smp_cur;
    smp_t  smp_prev;
    step_e step;
    logic  idx_hit;

    qpc_input_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_a   (phase_a),
        .raw_b   (phase_b),
        .raw_idx (index_in),
        .inv_a   (inv_a),
        .inv_b   (inv_b),
        .inv_idx (inv_idx),
        .swap_ab (swap_ab),
        .cur     (smp_cur),
        .prev    (smp_prev)
    );

    qpc_step_decode u_dec (
        .old_ab (smp_prev.ab),
        .new_ab (smp_cur.ab),
        .step   (step)
    );

    qpc_index_qual u_idx (
        .cur  (smp_cur),
        .prev (smp_prev),
        .gate (idx_gate),
        .hit  (idx_hit)
    );

    qpc_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk              (clk),
        .rst_n            (rst_n),
        .enable           (enable),
        .ceil_mode        (ceil_mode),
        .ceiling          (ceiling),
        .step             (step),
        .idx_hit          (idx_hit),
        .count            (count),
        .dir_up           (dir_up),
        .evt_dir_chg      (evt_dir_chg),
        .evt_wrap_up      (evt_wrap_up),
        .evt_wrap_dn      (evt_wrap_dn),
        .evt_phase_err    (evt_phase_err),
        .phase_err_sticky (phase_err_sticky)
    );

endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             ceil_mode,
    input logic [CNT_W-1:0] ceiling,
    input logic [CNT_W-1:0] count,
    input logic             dir_up,
    input logic             evt_dir_chg,
    input logic             evt_wrap_up,
    input logic             evt_wrap_dn,
    input logic             evt_phase_err,
    input logic             phase_err_sticky
);

    p_wrap_up_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wrap_up |-> (count == '0));

    p_wrap_dn_ceil_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wrap_dn && $past(ceil_mode)) |-> (count == $past(ceiling)));

    p_dir_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_dir_chg |-> (dir_up != $past(dir_up)));

    p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_phase_err |-> ($stable(count) && phase_err_sticky));

    p_evt_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_wrap_up, evt_wrap_dn, evt_phase_err}));

    p_hold_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> ($stable(count) && !evt_wrap_up && !evt_wrap_dn
                            && !evt_dir_chg && !evt_phase_err));

    p_rise_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && !$past(enable, 2)) |-> (count == '0 && !phase_err_sticky));

endmodule

bind quad_pos_counter qpc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .enable           (enable),
    .ceil_mode        (ceil_mode),
    .ceiling          (ceiling),
    .count            (count),
    .dir_up           (dir_up),
    .evt_dir_chg      (evt_dir_chg),
    .evt_wrap_up      (evt_wrap_up),
    .evt_wrap_dn      (evt_wrap_dn),
    .evt_phase_err    (evt_phase_err),
    .phase_err_sticky (phase_err_sticky)
);

// File: tb/quad_pos_counter_bench.sv
module quad_pos_counter_bench;

    localparam int W = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n;
    logic         in_en, in_a, in_b, in_i;
    logic         in_inv_a, in_inv_b, in_inv_i, in_swap, in_mode;
    logic [1:0]   in_gate;
    logic [W-1:0] in_ceil;
    logic [W-1:0] count;
    logic         dir_up, evt_dir_chg, evt_wrap_up, evt_wrap_dn, evt_phase_err, sticky;

    // configuration applied at the next drive
    logic         cfg_inv_a = 0, cfg_inv_b = 0, cfg_inv_i = 0, cfg_swap = 0, cfg_mode = 1;
    logic [1:0]   cfg_gate = 2'b11;
    logic [W-1:0] cfg_ceil = 32'd5;

    // requirement model state
    logic [1:0]   m_ab = 2'b00;
    logic         m_i = 0, m_en = 0, m_dir = 1, m_sticky = 0;
    logic [W-1:0] m_count = '0;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         dir;
        logic         wu;
        logic         wd;
        logic         dc;
        logic         pe;
        logic         st;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    quad_pos_counter #(.CNT_W(W)) u_quad_pos_counter (
        .clk              (clk),
        .rst_n            (rst_n),
        .enable           (in_en),
        .inv_a            (in_inv_a),
        .inv_b            (in_inv_b),
        .inv_idx          (in_inv_i),
        .swap_ab          (in_swap),
        .idx_gate         (in_gate),
        .ceil_mode        (in_mode),
        .ceiling          (in_ceil),
        .phase_a          (in_a),
        .phase_b          (in_b),
        .index_in         (in_i),
        .count            (count),
        .dir_up           (dir_up),
        .evt_dir_chg      (evt_dir_chg),
        .evt_wrap_up      (evt_wrap_up),
        .evt_wrap_dn      (evt_wrap_dn),
        .evt_phase_err    (evt_phase_err),
        .phase_err_sticky (sticky)
    );

    // forward order {A,B}: 00 -> 10 -> 11 -> 01 -> 00 (R2)
    function automatic logic [1:0] fwd_of(input logic [1:0] ab);
        case (ab)
            2'b00:   return 2'b10;
            2'b10:   return 2'b11;
            2'b11:   return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    // reverse order {A,B}: 00 -> 01 -> 11 -> 10 -> 00 (R3)
    function automatic logic [1:0] rev_of(input logic [1:0] ab);
        case (ab)
            2'b00:   return 2'b01;
            2'b01:   return 2'b11;
            2'b11:   return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic drive(input logic en, input logic pa, input logic pb,
                         input logic pi, input string tag);
        logic       ca, cb, ci, up, dn, err, nd;
        logic [1:0] nab;
        exp_t       e;
        @(negedge clk);
        in_en = en; in_a = pa; in_b = pb; in_i = pi;
        in_inv_a = cfg_inv_a; in_inv_b = cfg_inv_b; in_inv_i = cfg_inv_i;
        in_swap = cfg_swap; in_mode = cfg_mode; in_gate = cfg_gate; in_ceil = cfg_ceil;
        ca  = pa ^ cfg_inv_a;
        cb  = pb ^ cfg_inv_b;
        ci  = pi ^ cfg_inv_i;
        nab = cfg_swap ? {cb, ca} : {ca, cb};
        e   = '0;
        if (en && !m_en) begin
            m_count  = '0;
            m_sticky = 1'b0;
        end else if (en) begin
            up  = (nab == fwd_of(m_ab));
            dn  = (nab == rev_of(m_ab));
            err = (nab == ~m_ab);
            if (err) begin
                e.pe     = 1'b1;
                m_sticky = 1'b1;
            end else begin
                nd    = up ? 1'b1 : (dn ? 1'b0 : m_dir);
                e.dc  = (nd != m_dir);
                m_dir = nd;
                if (!cfg_mode && ci && !m_i && (nab == cfg_gate)) begin
                    m_count = '0;
                    e.wu    = nd;
                    e.wd    = ~nd;
                end else if (up) begin
                    if (cfg_mode && m_count == cfg_ceil) begin
                        m_count = '0;
                        e.wu    = 1'b1;
                    end else begin
                        m_count = m_count + 1;
                    end
                end else if (dn) begin
                    if (cfg_mode && m_count == '0) begin
                        m_count = cfg_ceil;
                        e.wd    = 1'b1;
                    end else begin
                        m_count = m_count - 1;
                    end
                end
            end
        end
        m_en  = en;
        m_ab  = nab;
        m_i   = ci;
        e.cnt = m_count;
        e.dir = m_dir;
        e.st  = m_sticky;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: one expected item per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  e;
                exp_t  a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = '{count, dir_up, evt_wrap_up, evt_wrap_dn, evt_dir_chg, evt_phase_err, sticky};
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s actual cnt=%h dir=%b wu=%b wd=%b dc=%b pe=%b st=%b expected cnt=%h dir=%b wu=%b wd=%b dc=%b pe=%b st=%b",
                             t, a.cnt, a.dir, a.wu, a.wd, a.dc, a.pe, a.st,
                             e.cnt, e.dir, e.wu, e.wd, e.dc, e.pe, e.st);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        in_en = 0; in_a = 0; in_b = 0; in_i = 0;
        in_inv_a = 0; in_inv_b = 0; in_inv_i = 0; in_swap = 0;
        in_mode = 1; in_gate = 2'b11; in_ceil = 32'd5;
        repeat (2) @(negedge clk);
        // R1: reset state
        checks++;
        if ({count, dir_up, evt_dir_chg, evt_wrap_up, evt_wrap_dn, evt_phase_err, sticky}
            !== {32'd0, 1'b1, 5'b0}) begin
            fails++;
            $display("FAIL R1 actual cnt=%h dir=%b expected cnt=0 dir=1", count, dir_up);
        end
        rst_n = 1;

        drive(1, 0, 0, 0, "R12");  // enable rise
        drive(1, 1, 0, 0, "R2");   // 1
        drive(1, 1, 1, 0, "R2");   // 2
        drive(1, 0, 1, 0, "R2");   // 3
        drive(1, 0, 0, 0, "R2");   // 4
        drive(1, 1, 0, 0, "R2");   // 5 = ceiling
        drive(1, 1, 1, 0, "R6");   // wrap to 0
        drive(1, 1, 0, 0, "R7");   // 0 down -> ceiling, reversal
        drive(1, 0, 0, 0, "R3");
        drive(1, 0, 1, 0, "R3");
        drive(1, 1, 0, 0, "R11");  // double transition
        drive(1, 1, 0, 0, "R11");  // sticky remains
        drive(1, 1, 1, 0, "R10");  // reversal to up
        drive(0, 0, 1, 0, "R12");  // disabled, step ignored
        drive(0, 0, 0, 0, "R12");
        drive(1, 0, 0, 0, "R12");  // rise clears count and sticky

        cfg_swap = 1;
        drive(0, 0, 0, 0, "R5");
        drive(1, 0, 0, 0, "R5");
        drive(1, 1, 0, 0, "R5");   // forward pin order counts down
        drive(1, 1, 1, 0, "R5");
        drive(1, 0, 1, 0, "R5");

        cfg_swap  = 0;
        cfg_inv_a = 1;
        drive(0, 0, 1, 0, "R4");
        drive(1, 0, 1, 0, "R4");
        drive(1, 1, 1, 0, "R4");
        drive(1, 1, 0, 0, "R4");

        cfg_gate = 2'b00;
        drive(1, 1, 0, 1, "R8");   // ceiling mode: index ignored
        drive(1, 1, 0, 0, "R8");

        cfg_inv_a = 0;
        cfg_mode  = 0;
        cfg_gate  = 2'b10;
        drive(0, 0, 0, 0, "R9");
        drive(1, 0, 0, 0, "R9");
        drive(1, 0, 1, 0, "R9");   // below zero, free wrap
        drive(1, 0, 0, 0, "R9");   // back over the top
        drive(1, 0, 0, 1, "R8");   // levels do not match gate
        drive(1, 0, 0, 0, "R8");
        drive(1, 1, 0, 0, "R8");
        drive(1, 1, 1, 0, "R8");
        drive(1, 1, 0, 0, "R8");
        drive(1, 1, 1, 0, "R8");
        drive(1, 1, 0, 1, "R8");   // step down and qualified index together
        drive(1, 1, 0, 1, "R8");   // index held high: no new edge
        drive(1, 1, 0, 0, "R8");
        drive(1, 1, 1, 0, "R8");
        cfg_inv_i = 1;
        drive(1, 0, 1, 1, "R4");
        drive(1, 0, 0, 1, "R4");
        drive(1, 1, 0, 0, "R4");   // inverted index rises with matching levels

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule